// File: doc/BRIEF.md
# Masked Substitution Table Generator

This block prepares a masked copy of the forward AES substitution table in an external 256-entry RAM before any encryption work starts. After a one-cycle start strobe it walks through all indices and writes, at index i, the substitution of (i XOR in_mask) with out_mask XORed onto the result. In the stored table both the address used for a lookup and the value that comes back are hidden by a byte-wide random mask.

The masks are supplied with the start strobe and latched, so the random source may move on once the fill has begun. The substitution values come from a constant table inside the block. A generate option picks one of two forms for that table: one built at elaboration, or an arithmetic field-inverse circuit. The cipher that reads the table waits for the done pulse.

Top module: `msbox_gen`

## Requirements
- R1: After reset, wr_en_o, busy_o and done_o are all 0.
- R2: The word written at address i equals S(i XOR in_mask) XOR out_mask, where S is the forward AES substitution (field inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine map with constant 0x63).
- R3: One write is issued per cycle, with addresses 0, 1, ..., 255 in ascending order, and each address is written exactly once per fill.
- R4: A start strobe sampled while idle raises busy_o on the next cycle. busy_o and wr_en_o then stay high for exactly 256 cycles, and wr_en_o is 0 whenever busy_o is 0.
- R5: done_o pulses high for exactly one cycle, in the cycle right after the last write (address 255), with busy_o already low.
- R6: Both mask bytes are latched on the accepted start. Changes on in_mask_i or out_mask_i during a fill do not affect any written word.
- R7: A start strobe sampled while busy_o is high is ignored. The fill keeps its masks, its address order and its 256-cycle length.
- R8: For every byte x, the word at address (x XOR in_mask), once XORed with out_mask, gives back S(x).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fill (single-cycle strobe) |
| in_mask_i | input | 8 | Input-side mask, latched at start |
| out_mask_i | input | 8 | Output-side mask, latched at start |
| wr_en_o | output | 1 | RAM write enable |
| wr_addr_o | output | 8 | RAM write address |
| wr_data_o | output | 8 | RAM write data |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
Full fills are run with mask pairs (0,0), (0xFF,0), (0,0xFF) and (0x5A,0xC3). The all-zero pair checks the plain substitution table. Each single-sided mask isolates the address permutation from the data XOR, and the mixed pair shows that the two are combined in the right order. Every run captures all 256 writes into a bench memory and compares them against a substitution computed from log and antilog tables. In one run the mask inputs are changed and a second start is raised part way through, which checks the latching and the busy guard against the written data.

// File: rtl/msbox_pkg.sv
package msbox_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam logic [7:0] FIELD_POLY = 8'h1B;
   localparam logic [7:0] AFFINE_C = 8'h63;

   typedef logic [BYTE_W-1:0] byte_t;

   function automatic byte_t gf_mul(input byte_t a, input byte_t b);
      byte_t acc;
      byte_t sh;
      acc = '0;
      sh  = a;
      for (int k = 0; k < BYTE_W; k++) begin
         if (b[k]) acc = acc ^ sh;
         sh = sh[7] ? ((sh << 1) ^ FIELD_POLY) : (sh << 1);
      end
      return acc;
   endfunction

   // x^254 is the multiplicative inverse; zero maps to zero.
   function automatic byte_t gf_inv(input byte_t x);
      byte_t res;
      byte_t pw;
      logic [7:0] ex;
      res = 8'h01;
      pw  = x;
      ex  = 8'd254;
      for (int k = 0; k < BYTE_W; k++) begin
         if (ex[k]) res = gf_mul(res, pw);
         pw = gf_mul(pw, pw);
      end
      return res;
   endfunction

   function automatic byte_t rotl(input byte_t v, input int unsigned n);
      return byte_t'((v << n) | (v >> (BYTE_W - n)));
   endfunction

   function automatic byte_t subst(input byte_t x);
      byte_t b;
      b = gf_inv(x);
      return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ AFFINE_C;
   endfunction

endpackage

// File: rtl/msbox_sub.sv
module msbox_sub
   import msbox_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          USE_LUT  = 1'b1
) (
   input  logic [DATA_W-1:0] idx_i,
   output logic [DATA_W-1:0] val_o
);
   localparam int unsigned ENTRIES = 1 << DATA_W;

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("msbox_sub: DATA_W must equal 8");
      end

      if (USE_LUT) begin : g_lut
         logic [DATA_W-1:0] rom [ENTRIES];
         for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            assign rom[g] = subst(byte_t'(g));
         end
         assign val_o = rom[idx_i];
      end else begin : g_arith
         always_comb val_o = subst(idx_i);
      end
   endgenerate
endmodule

// File: rtl/msbox_mask.sv
module msbox_mask #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] in_mask_i,
   input  logic [DATA_W-1:0] out_mask_i,
   input  logic [DATA_W-1:0] idx_i,
   input  logic [DATA_W-1:0] sub_val_i,
   output logic [DATA_W-1:0] sub_idx_o,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] in_q;
   logic [DATA_W-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         out_q <= '0;
      end else if (load_i) begin
         in_q  <= in_mask_i;
         out_q <= out_mask_i;
      end
   end

   assign sub_idx_o = idx_i ^ in_q;
   assign data_o    = sub_val_i ^ out_q;
endmodule

// File: rtl/msbox_seq.sv
module msbox_seq #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              load_o,
   output logic              active_o,
   output logic [ADDR_W-1:0] idx_o,
   output logic              fin_o
);
   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

   logic              run_q;
   logic              fin_q;
   logic [ADDR_W-1:0] idx_q;
   logic              at_end;

   assign at_end = run_q && (idx_q == LAST);
   assign load_o = start_i && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         fin_q <= 1'b0;
         idx_q <= '0;
      end else begin
         fin_q <= at_end;
         if (load_o) begin
            run_q <= 1'b1;
            idx_q <= '0;
         end else if (run_q) begin
            idx_q <= idx_q + 1'b1;
            if (at_end) run_q <= 1'b0;
         end
      end
   end

   assign active_o = run_q;
   assign idx_o    = idx_q;
   assign fin_o    = fin_q;
endmodule

// File: rtl/msbox_gen.sv
module msbox_gen #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter bit          USE_LUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] in_mask_i,
   input  logic [DATA_W-1:0] out_mask_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              done_o
);
   generate
      if (ADDR_W != DATA_W) begin : g_bad_geom
         $error("msbox_gen: ADDR_W must equal DATA_W so every index is covered");
      end
   endgenerate

   logic              load;
   logic              active;
   logic [ADDR_W-1:0] idx;
   logic [DATA_W-1:0] sub_idx;
   logic [DATA_W-1:0] sub_val;

   msbox_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .load_o   (load),
      .active_o (active),
      .idx_o    (idx),
      .fin_o    (done_o)
   );

   msbox_mask #(.DATA_W(DATA_W)) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .in_mask_i  (in_mask_i),
      .out_mask_i (out_mask_i),
      .idx_i      (DATA_W'(idx)),
      .sub_val_i  (sub_val),
      .sub_idx_o  (sub_idx),
      .data_o     (wr_data_o)
   );

   msbox_sub #(.DATA_W(DATA_W), .USE_LUT(USE_LUT)) u_sub (
      .idx_i (sub_idx),
      .val_o (sub_val)
   );

   assign wr_en_o   = active;
   assign wr_addr_o = idx;
   assign busy_o    = active;
endmodule

// File: rtl/msbox_gen_chk.sv
module msbox_gen_chk #(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic              busy_o,
   input logic              done_o
);
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));

   a_r4_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && wr_en_o && wr_addr_o == '0));

   a_r5_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(wr_en_o) && $past(wr_addr_o) == TOP && !busy_o));

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && wr_addr_o != TOP) |=> (busy_o && wr_addr_o == $past(wr_addr_o) + 1'b1));
endmodule

bind msbox_gen msbox_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o),
   .busy_o    (busy_o),
   .done_o    (done_o)
);

// File: tb/tb_msbox_gen.sv
module tb_msbox_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] in_mask_i = '0;
   logic [7:0] out_mask_i = '0;
   logic       wr_en_o;
   logic [7:0] wr_addr_o;
   logic [7:0] wr_data_o;
   logic       busy_o;
   logic       done_o;

   int tests = 0;
   int fails = 0;
   logic [7:0] ram   [256];
   logic [7:0] expt  [256];
   logic [7:0] logt  [256];
   logic [7:0] ref_s [256];

   always #10 clk = ~clk;

   msbox_gen dut (.*);

   function automatic logic [7:0] xt(input logic [7:0] v);
      return v[7] ? ((v << 1) ^ 8'h1B) : (v << 1);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic build_ref();
      logic [7:0] e;
      logic [7:0] inv;
      e = 8'h01;
      for (int i = 0; i < 255; i++) begin
         expt[i] = e;
         logt[e] = 8'(i);
         e = e ^ xt(e);
      end
      for (int x = 0; x < 256; x++) begin
         inv = (x == 0) ? 8'h00 : expt[(255 - int'(logt[x])) % 255];
         for (int b = 0; b < 8; b++)
            ref_s[x][b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8]
                          ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 1'b1);
      end
   endtask

   // Runs one fill with masks m_in/m_out; disturb adds mask changes and a second start mid-fill.
   task automatic run_fill(input logic [7:0] m_in, input logic [7:0] m_out, input bit disturb);
      int order_bad;
      int data_bad;
      int rec_bad;
      order_bad = 0; data_bad = 0; rec_bad = 0;
      @(negedge clk);
      start_i = 1'b1; in_mask_i = m_in; out_mask_i = m_out;
      @(negedge clk);
      start_i = 1'b0;
      if (disturb) begin in_mask_i = ~m_in; out_mask_i = m_out ^ 8'h3C; end
      chk(busy_o == 1'b1, "R4 busy after start", busy_o, 1);
      for (int k = 0; k < 256; k++) begin
         if (k > 0) @(negedge clk);
         if (disturb && k == 100) start_i = 1'b1;
         if (disturb && k == 101) start_i = 1'b0;
         if (!(wr_en_o && busy_o && wr_addr_o == 8'(k))) order_bad++;
         ram[wr_addr_o] = wr_data_o;
      end
      chk(order_bad == 0, "R3 ascending single writes", order_bad, 0);
      for (int i = 0; i < 256; i++)
         if (ram[i] != (ref_s[i ^ m_in] ^ m_out)) data_bad++;
      chk(data_bad == 0, disturb ? "R6 R7 data keeps latched masks" : "R2 masked entries",
          data_bad, 0);
      for (int x = 0; x < 256; x++)
         if ((ram[x ^ m_in] ^ m_out) != ref_s[x]) rec_bad++;
      chk(rec_bad == 0, "R8 unmask recovers S", rec_bad, 0);
      @(negedge clk);
      chk(done_o == 1'b1 && busy_o == 1'b0 && wr_en_o == 1'b0, "R5 done after last write",
          {done_o, busy_o, wr_en_o}, 3'b100);
      @(negedge clk);
      chk(done_o == 1'b0 && wr_en_o == 1'b0, "R5 done single pulse", done_o, 0);
      in_mask_i = '0; out_mask_i = '0;
   endtask

   initial begin
      #4_000_000;
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      build_ref();
      chk(ref_s[8'h00] == 8'h63 && ref_s[8'h53] == 8'hED, "R2 reference table",
          ref_s[8'h53], 8'hED);
      repeat (3) @(negedge clk);
      chk(!wr_en_o && !busy_o && !done_o, "R1 reset state",
          {wr_en_o, busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!wr_en_o && !busy_o && !done_o, "R1 idle after reset",
          {wr_en_o, busy_o, done_o}, 0);
      run_fill(8'h00, 8'h00, 1'b0);
      run_fill(8'hFF, 8'h00, 1'b0);
      run_fill(8'h00, 8'hFF, 1'b0);
      run_fill(8'h5A, 8'hC3, 1'b0);
      run_fill(8'hA7, 8'h19, 1'b1);
      repeat (5) @(negedge clk);
      chk(!busy_o && !wr_en_o, "R7 no extra fill from ignored start",
          {busy_o, wr_en_o}, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule